// File: doc/BRIEF.md
# Pipelined 16-bit SPI Register Slave

This block is a serial register slave that talks to a host over a four-wire SPI link (chip select, clock, data in, data out) in clock mode 1. The clock idles low, the slave shifts its output on the rising edge, and it samples its input on the falling edge. Every transfer is a 16-bit word, most significant bit first. The host sends a command word and receives a response word in the same transfer. The response always belongs to the command from the previous transfer, so a read costs two transfers. A write costs two transfers as well: the command word, then a data word.

The serial pins are not clocked by the system clock. They pass through two-flop synchronizers, and the SCK edges are found in the system clock domain. For that reason SCK must run well below the system clock rate.

Each word carries an even parity bit in bit 15. Each response also carries a sticky error flag in bit 14. When any error occurs, the slave sets that flag and records the cause. Reading the error register returns the recorded causes and then clears both the causes and the flag.

The register side has these inputs:
- a raw 14-bit angle
- a 14-bit magnitude
- an 8-bit gain value
- four diagnostic flags

It drives the programmed zero position and a programming-control byte, which stand in for one-time-programmable storage. The angle register returns the raw angle minus the zero position, modulo 2^14.

Top module: `spi_reg_slave`

## Requirements
- R1: A transfer is valid when exactly 16 falling SCK edges occur while CSn is low. MOSI is sampled on each falling edge, MSB first. MISO presents the response MSB first and changes after each rising edge. MISO is 0 while CSn is high, and taking CSn high restarts the shift logic.
- R2: The response sent during a transfer is the one produced by the previous valid transfer. After reset the response is 0x0000.
- R3: Every response word has even parity over all 16 bits, so bit 15 is the XOR of bits 14:0. Bit 14 is the sticky error flag as it stood after the previous transfer was processed.
- R4: A command word whose 16 bits have odd parity sets cause bit 2 and the error flag. The slave ignores the command and the next response data is 0.
- R5: Bit 14 = 0 in a nonzero command means write, and bits 13:0 are the address. The next transfer is the data word. That data transfer returns the register's old content, and the transfer after it returns the new content.
- R6: The following set cause bit 1 and the error flag, and leave the registers unchanged:
  - a read of an unmapped address
  - a write to a read-only or unmapped address
  - a data word with bit 14 = 1

  The first two give a response data value of 0.
- R7: A transfer with a clock count other than 16 sets cause bit 0 and the error flag. The slave discards it and cancels a pending write. The response data of the previous transfer is repeated, with the error flag updated.
- R8: A read of address 0x0001 returns the cause bits in data bits 2:0, with the error flag set, in the next transfer. It then clears the causes and the flag.
- R9: The all-zero word is a no-operation. Its response data is 0, so with no error pending the whole response is 0x0000.
- R10: Address 0x3FFD reads {2'b0, comp_high, comp_low, cordic_ovf, offset_done, gain[7:0]}, and address 0x3FFE reads the magnitude.
- R11: Address 0x3FFF reads the raw angle minus the zero position, modulo 2^14.
- R12: The registers behave as follows, and zero_pos and prog_ctrl change only after a transfer ends:
  - Address 0x0016 holds zero position bits 13:6 in data bits 7:0.
  - Address 0x0017 holds zero position bits 5:0 in data bits 5:0.
  - Address 0x0003 holds the programming-control byte. Only bits 0, 3 and 6 are stored, and the others read 0.
  - All of these reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, idles low, asynchronous |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| angle_raw | input | 14 | Uncorrected angle sample |
| magnitude | input | 14 | Field magnitude sample |
| gain | input | 8 | Automatic gain value |
| comp_high | input | 1 | Diagnostic: field too weak flag |
| comp_low | input | 1 | Diagnostic: field too strong flag |
| cordic_ovf | input | 1 | Diagnostic: angle computation overflow |
| offset_done | input | 1 | Diagnostic: offset compensation finished |
| zero_pos | output | 14 | Programmed zero position |
| prog_ctrl | output | 8 | Programming-control byte (bits 0, 3, 6) |

## Verification
The assertions assume the following about the serial pins:
- CSn, SCK and MOSI each hold every level for several system clocks.
- SCK is low whenever CSn changes.
- MOSI changes only while SCK is high.

Under these assumptions the synchronized edges never merge and a frame end never coincides with a clock edge. The stimulus holds each SCK phase for eight system clocks and leaves eight clocks between CSn and the nearest SCK edge. It keeps CSn high for sixteen clocks between transfers, so the response register is settled before the next transfer loads it.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int FRAME_W   = 16;
  localparam int DATA_W    = 14;
  localparam int AGC_W     = 8;
  localparam int PROG_W    = 8;
  localparam int CAUSE_W   = 3;
  localparam int ZP_SPLIT  = 6;

  localparam logic [DATA_W-1:0] ADDR_ERR   = 14'h0001;
  localparam logic [DATA_W-1:0] ADDR_PROG  = 14'h0003;
  localparam logic [DATA_W-1:0] ADDR_ZP_HI = 14'h0016;
  localparam logic [DATA_W-1:0] ADDR_ZP_LO = 14'h0017;
  localparam logic [DATA_W-1:0] ADDR_DIAG  = 14'h3FFD;
  localparam logic [DATA_W-1:0] ADDR_MAG   = 14'h3FFE;
  localparam logic [DATA_W-1:0] ADDR_ANG   = 14'h3FFF;

  localparam logic [PROG_W-1:0] PROG_MASK = 8'h49;

  localparam int CAUSE_FRAME = 0;
  localparam int CAUSE_CMD   = 1;
  localparam int CAUSE_PAR   = 2;

  typedef struct packed {
    logic              par;
    logic              rd;
    logic [DATA_W-1:0] addr;
  } cmd_word_t;

  typedef struct packed {
    logic              hit;
    logic [DATA_W-1:0] data;
  } lookup_t;

  function automatic logic [FRAME_W-1:0] make_resp(input logic ef, input logic [DATA_W-1:0] d);
    return {^{ef, d}, ef, d};
  endfunction
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d_async;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srs_shifter.sv
module srs_shifter #(
  parameter int FRAME_BITS = 16,
  localparam int CNT_W     = $clog2(FRAME_BITS) + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csn_s,
  input  logic                  csn_rise,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic                  mosi_s,
  input  logic [FRAME_BITS-1:0] load_word,
  output logic                  miso,
  output logic                  frame_done,
  output logic                  frame_ok,
  output logic [FRAME_BITS-1:0] frame_word
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_EXACT = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] tx_sr, rx_sr;
  logic [CNT_W-1:0]      edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr      <= '0;
      rx_sr      <= '0;
      edge_cnt   <= '0;
      miso       <= 1'b0;
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
      frame_word <= '0;
    end else begin
      frame_done <= 1'b0;
      if (csn_s) begin
        edge_cnt <= '0;
        tx_sr    <= load_word;
        miso     <= 1'b0;
      end else begin
        if (sck_rise) begin
          miso  <= tx_sr[FRAME_BITS-1];
          tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
        end
        if (sck_fall) begin
          rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s};
          if (edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
        end
      end
      if (csn_rise) begin
        frame_done <= 1'b1;
        frame_ok   <= (edge_cnt == CNT_EXACT);
        frame_word <= rx_sr;
      end
    end
  end
endmodule

// File: rtl/srs_engine.sv
module srs_engine
  import srs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic               frame_ok,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic [DATA_W-1:0]  angle_raw,
  input  logic [DATA_W-1:0]  magnitude,
  input  logic [AGC_W-1:0]   gain,
  input  logic [3:0]         diag_bits,
  output logic [FRAME_W-1:0] resp_q,
  output logic [DATA_W-1:0]  zero_pos,
  output logic [PROG_W-1:0]  prog_ctrl,
  output logic               err_flag
);
  logic [CAUSE_W-1:0] cause_q, cause_nx, cause_set;
  logic [DATA_W-1:0]  zp_nx, paddr_q, paddr_nx, resp_data;
  logic [PROG_W-1:0]  pc_nx;
  logic               pend_q, pend_nx, flag_nx, clr, par_ok;
  logic [FRAME_W-1:0] resp_nx;
  cmd_word_t          cw;
  lookup_t            lk;

  function automatic lookup_t reg_read(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] zp,
                                       input logic [PROG_W-1:0] pc, input logic [CAUSE_W-1:0] cs);
    lookup_t r;
    r.hit = 1'b1;
    unique case (a)
      ADDR_ERR:   r.data = DATA_W'(cs);
      ADDR_PROG:  r.data = DATA_W'(pc);
      ADDR_ZP_HI: r.data = DATA_W'(zp[DATA_W-1:ZP_SPLIT]);
      ADDR_ZP_LO: r.data = DATA_W'(zp[ZP_SPLIT-1:0]);
      ADDR_DIAG:  r.data = {2'b00, diag_bits, gain};
      ADDR_MAG:   r.data = magnitude;
      ADDR_ANG:   r.data = angle_raw - zp;
      default: begin r.hit = 1'b0; r.data = '0; end
    endcase
    return r;
  endfunction

  function automatic logic writable(input logic [DATA_W-1:0] a);
    return (a == ADDR_PROG) || (a == ADDR_ZP_HI) || (a == ADDR_ZP_LO);
  endfunction

  always_comb begin
    cw        = frame_word;
    par_ok    = ~^frame_word;
    cause_set = '0;
    zp_nx     = zero_pos;
    pc_nx     = prog_ctrl;
    pend_nx   = pend_q;
    paddr_nx  = paddr_q;
    resp_data = resp_q[DATA_W-1:0];
    clr       = 1'b0;
    lk        = reg_read(cw.addr, zero_pos, prog_ctrl, cause_q);
    if (!frame_ok) begin
      cause_set[CAUSE_FRAME] = 1'b1;
      pend_nx = 1'b0;
    end else if (pend_q) begin
      pend_nx = 1'b0;
      if (!par_ok) cause_set[CAUSE_PAR] = 1'b1;
      else if (cw.rd) cause_set[CAUSE_CMD] = 1'b1;
      else begin
        unique case (paddr_q)
          ADDR_PROG:  pc_nx = frame_word[PROG_W-1:0] & PROG_MASK;
          ADDR_ZP_HI: zp_nx[DATA_W-1:ZP_SPLIT] = frame_word[DATA_W-ZP_SPLIT-1:0];
          ADDR_ZP_LO: zp_nx[ZP_SPLIT-1:0] = frame_word[ZP_SPLIT-1:0];
          default: ;
        endcase
      end
      resp_data = reg_read(paddr_q, zp_nx, pc_nx, cause_q).data;
    end else if (!par_ok) begin
      cause_set[CAUSE_PAR] = 1'b1;
      resp_data = '0;
    end else if (frame_word == '0) begin
      resp_data = '0;
    end else if (cw.rd) begin
      if (!lk.hit) begin
        cause_set[CAUSE_CMD] = 1'b1;
        resp_data = '0;
      end else begin
        resp_data = lk.data;
        clr = (cw.addr == ADDR_ERR);
      end
    end else if (writable(cw.addr)) begin
      pend_nx   = 1'b1;
      paddr_nx  = cw.addr;
      resp_data = lk.data;
    end else begin
      cause_set[CAUSE_CMD] = 1'b1;
      resp_data = '0;
    end
    cause_nx = cause_q | cause_set;
    flag_nx  = err_flag | (|cause_set);
    resp_nx  = make_resp(flag_nx, resp_data);
    if (clr) begin
      cause_nx = '0;
      flag_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q    <= '0;
      zero_pos  <= '0;
      prog_ctrl <= '0;
      err_flag  <= 1'b0;
      cause_q   <= '0;
      pend_q    <= 1'b0;
      paddr_q   <= '0;
    end else if (frame_done) begin
      resp_q    <= resp_nx;
      zero_pos  <= zp_nx;
      prog_ctrl <= pc_nx;
      err_flag  <= flag_nx;
      cause_q   <= cause_nx;
      pend_q    <= pend_nx;
      paddr_q   <= paddr_nx;
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import srs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [DATA_W-1:0] angle_raw,
  input  logic [DATA_W-1:0] magnitude,
  input  logic [AGC_W-1:0]  gain,
  input  logic              comp_high,
  input  logic              comp_low,
  input  logic              cordic_ovf,
  input  logic              offset_done,
  output logic [DATA_W-1:0] zero_pos,
  output logic [PROG_W-1:0] prog_ctrl
);
  logic [2:0]         pins_s;
  logic               csn_s, sck_s, mosi_s, csn_p, sck_p;
  logic               csn_rise, sck_rise, sck_fall;
  logic               frame_done, frame_ok, err_flag;
  logic [FRAME_W-1:0] frame_word, resp_q;

  srs_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({spi_csn, spi_sck, spi_mosi}),
    .q(pins_s)
  );

  assign {csn_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_p <= 1'b1;
      sck_p <= 1'b0;
    end else begin
      csn_p <= csn_s;
      sck_p <= sck_s;
    end
  end

  assign csn_rise = csn_s & ~csn_p;
  assign sck_rise = sck_s & ~sck_p;
  assign sck_fall = ~sck_s & sck_p;

  srs_shifter #(.FRAME_BITS(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .csn_s(csn_s), .csn_rise(csn_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(mosi_s), .load_word(resp_q),
    .miso(spi_miso), .frame_done(frame_done),
    .frame_ok(frame_ok), .frame_word(frame_word)
  );

  srs_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .frame_done(frame_done), .frame_ok(frame_ok), .frame_word(frame_word),
    .angle_raw(angle_raw), .magnitude(magnitude), .gain(gain),
    .diag_bits({comp_high, comp_low, cordic_ovf, offset_done}),
    .resp_q(resp_q), .zero_pos(zero_pos), .prog_ctrl(prog_ctrl),
    .err_flag(err_flag)
  );
endmodule

// File: rtl/srs_checker.sv
module srs_checker
  import srs_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               csn_s,
  input logic               miso,
  input logic               frame_done,
  input logic [FRAME_W-1:0] resp_word,
  input logic               err_flag,
  input logic [DATA_W-1:0]  zero_pos,
  input logic [PROG_W-1:0]  prog_ctrl
);
  // R3: the staged response is always even parity
  a_r3_resp_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (^resp_word) == 1'b0);

  // R1: MISO stays low while CSn is held high
  a_r1_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> !miso);

  // R12: registers never move inside a transfer
  a_r12_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_s && !$past(csn_s)) |-> ($stable(zero_pos) && $stable(prog_ctrl)));

  // R12: only the three control bits can be set
  a_r12_prog_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ctrl & ~PROG_MASK) == '0);

  // R8: the flag clears only as a transfer is processed
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(frame_done));

  // R2: the response changes only at a transfer boundary
  a_r2_resp_update: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(resp_word) |-> $past(frame_done));
endmodule

bind spi_reg_slave srs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .miso(spi_miso),
  .frame_done(frame_done), .resp_word(resp_q), .err_flag(err_flag),
  .zero_pos(zero_pos), .prog_ctrl(prog_ctrl)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  logic [13:0] angle_raw = 14'h1234, magnitude = 14'h0ABC;
  logic [7:0]  gain = 8'h5A;
  logic comp_high = 1'b1, comp_low = 1'b0, cordic_ovf = 1'b1, offset_done = 1'b1;
  logic [13:0] zero_pos;
  logic [7:0]  prog_ctrl;

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0, finished = 1'b0;

  // behavioural reference state
  logic [15:0] m_resp = 16'h0000;
  bit          m_flag = 1'b0, m_pend = 1'b0;
  int          m_cause = 0, m_paddr = 0, m_zp = 0, m_pc = 0;

  always #4 clk = ~clk;

  spi_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .angle_raw(angle_raw), .magnitude(magnitude), .gain(gain),
    .comp_high(comp_high), .comp_low(comp_low), .cordic_ovf(cordic_ovf),
    .offset_done(offset_done), .zero_pos(zero_pos), .prog_ctrl(prog_ctrl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R12: outputs compared against the model on every clock between transfers
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(zero_pos == 14'(m_zp), "R12 zero_pos", int'(zero_pos), m_zp);
      chk(prog_ctrl == 8'(m_pc), "R12 prog_ctrl", int'(prog_ctrl), m_pc);
    end
  end

  function automatic logic [15:0] cmd(input bit rd, input int addr);
    logic [13:0] a = 14'(addr);
    return {^{rd, a}, rd, a};
  endfunction

  function automatic logic [15:0] dat(input bit b14, input int d);
    logic [13:0] v = 14'(d);
    return {^{b14, v}, b14, v};
  endfunction

  function automatic int m_read(input int a);
    case (a)
      'h0001: return m_cause;
      'h0003: return m_pc;
      'h0016: return (m_zp >> 6) & 'hFF;
      'h0017: return m_zp & 'h3F;
      'h3FFD: return (int'(comp_high) << 11) | (int'(comp_low) << 10) |
                     (int'(cordic_ovf) << 9) | (int'(offset_done) << 8) | int'(gain);
      'h3FFE: return int'(magnitude);
      'h3FFF: return (int'(angle_raw) - m_zp + 16384) % 16384;
      default: return -1;
    endcase
  endfunction

  task automatic model(input logic [15:0] w, input int nclk);
    int setc = 0, d;
    bit clr = 1'b0;
    int addr = int'(w[13:0]);
    d = int'(m_resp[13:0]);
    if (nclk != 16) begin
      setc = 1; m_pend = 1'b0;
    end else if (m_pend) begin
      m_pend = 1'b0;
      if (^w) setc = 4;
      else if (w[14]) setc = 2;
      else if (m_paddr == 'h0003) m_pc = addr & 'h49;
      else if (m_paddr == 'h0016) m_zp = (m_zp & 'h3F) | ((addr & 'hFF) << 6);
      else m_zp = (m_zp & 'h3FC0) | (addr & 'h3F);
      d = m_read(m_paddr);
    end else if (^w) begin
      setc = 4; d = 0;
    end else if (w == 16'h0000) begin
      d = 0;
    end else if (w[14]) begin
      if (m_read(addr) < 0) begin setc = 2; d = 0; end
      else begin d = m_read(addr); clr = (addr == 1); end
    end else if (addr == 'h0003 || addr == 'h0016 || addr == 'h0017) begin
      m_pend = 1'b1; m_paddr = addr; d = m_read(addr);
    end else begin
      setc = 2; d = 0;
    end
    m_cause = m_cause | setc;
    m_flag  = m_flag || (setc != 0);
    m_resp  = {^{m_flag, 14'(d)}, m_flag, 14'(d)};
    if (clr) begin m_cause = 0; m_flag = 1'b0; end
  endtask

  task automatic xfer(input logic [15:0] w, input int nclk, input string tag);
    logic [15:0] got = '0;
    logic [15:0] exp = m_resp;
    @(negedge clk);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sck  = 1'b1;
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      got = {got[14:0], miso};
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cmp_en = 1'b0;
    csn  = 1'b1;
    mosi = 1'b0;
    if (nclk == 16) chk(got == exp, tag, int'(got), int'(exp));
    model(w, nclk);
    repeat (16) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // reset state (R1, R12)
    chk(miso == 1'b0, "R1 miso idle at reset", int'(miso), 0);
    chk(zero_pos == 14'h0, "R12 zero_pos reset", int'(zero_pos), 0);
    chk(prog_ctrl == 8'h0, "R12 prog_ctrl reset", int'(prog_ctrl), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    xfer(16'h0000,         16, "R2 first response zero");
    xfer(cmd(1, 'h3FFF),   16, "R9 nop response");
    xfer(cmd(1, 'h3FFE),   16, "R11 raw angle");
    xfer(cmd(1, 'h3FFD),   16, "R10 magnitude");
    xfer(16'h0000,         16, "R10 diagnostics");
    xfer(cmd(0, 'h0017),   16, "R9 nop again");
    xfer(dat(0, 'h0005),   16, "R5 old zero low");
    xfer(cmd(0, 'h0016),   16, "R5 new zero low");
    xfer(dat(0, 'h3F12),   16, "R5 old zero high");
    xfer(cmd(1, 'h3FFF),   16, "R5 new zero high");
    xfer(cmd(0, 'h0003),   16, "R11 corrected angle");
    xfer(dat(0, 'h00FF),   16, "R5 old prog ctrl");
    xfer(16'h0000,         16, "R12 prog ctrl masked");
    xfer(cmd(1, 'h3FFE) ^ 16'h8000, 16, "R1 mosi msb first");
    xfer(16'h0000,         16, "R4 parity error response");
    xfer(cmd(1, 'h3FFE),   10, "R7 short transfer");
    xfer(16'h0000,         16, "R7 repeated response after short");
    xfer(cmd(1, 'h0100),   16, "R3 flagged nop");
    xfer(cmd(1, 'h0001),   16, "R6 invalid address response");
    xfer(16'h0000,         16, "R8 cause bits returned");
    xfer(16'h0000,         16, "R8 flag cleared");
    xfer(cmd(0, 'h0016),   16, "R9 clean nop");
    xfer(dat(1, 'h0001),   16, "R6 old content on bad data");
    xfer(cmd(0, 'h3FFF),   16, "R6 data frame rejected");
    xfer(cmd(1, 'h0016),   20, "R7 long transfer");
    xfer(cmd(1, 'h0001),   16, "R6 repeated after long");
    xfer(16'h0000,         16, "R8 cause after invalid and framing");
    xfer(16'h0000,         16, "R8 cleared again");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule